// File: doc/BRIEF.md
# Read-After-Write Interlock for a Pipeline Without Forwarding

This block is the stall decision logic for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) with no bypass paths. Every cycle it looks at the two source register numbers of the instruction sitting in decode and compares each one with the destination register of the instructions now in execute and in memory. If a source that the decode instruction really reads matches the destination of an older instruction that will write the register file, that value is not yet readable. The block then freezes the program counter and the fetch/decode register, and tells the decode/execute register to load a bubble in place of the decoded instruction.

The decision is purely combinational from the current pipeline register contents. The register file writes early in a cycle and reads late in it, so a producer that has reached writeback is already visible to decode and is not compared. Because no result is ever forwarded, a producer immediately ahead of its consumer holds it for two cycles, a producer two slots ahead holds it for one, and a producer three slots ahead costs nothing. A store's data register counts as a source like any other operand. Register 0 is hardwired to zero and never causes a hold.

Top module: `hazard_interlock`

## Requirements
- R1: When the execute-stage instruction has its register-write flag set, a nonzero destination, and that destination equals the decode first source with its use flag set, the block stalls: pcWrite=0, ifIdWrite=0, bubbleSel=1.
- R2: A memory-stage instruction with register-write set and a nonzero destination matching either used decode source stalls the pipeline exactly as in R1.
- R3: The second source is compared whenever its use flag is set, so a store whose data register was written by the instruction just ahead of it stalls.
- R4: A source whose use flag is 0 never causes a stall, whatever its register number.
- R5: A producer whose register-write flag is 0 never causes a stall, whatever its destination number.
- R6: A producer whose destination is register 0 never causes a stall.
- R7: With no qualifying match the outputs are pcWrite=1, ifIdWrite=1, bubbleSel=0.
- R8: The three outputs are always coherent: ifIdWrite equals pcWrite and bubbleSel equals its inverse.
- R9: Driven by a pipeline that advances on pcWrite=1 and loads a bubble into execute on bubbleSel=1, a consumer immediately after its producer is held for 2 cycles, one slot later for 1 cycle, and three or more slots later for 0 cycles; the sequence add r5,r2,r1 / load r3,4(r5) / load r2,0(r2) / or r3,r5,r3 / store r3,0(r5) gives holds of 0,2,0,1,2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | REG_W | First source register number of the decode instruction |
| idRs1Used | input | 1 | Decode instruction reads its first source |
| idRs2 | input | REG_W | Second source register number of the decode instruction (store data included) |
| idRs2Used | input | 1 | Decode instruction reads its second source |
| exRd | input | REG_W | Destination register number of the execute-stage instruction |
| exRegWrite | input | 1 | Execute-stage instruction writes the register file |
| memRd | input | REG_W | Destination register number of the memory-stage instruction |
| memRegWrite | input | 1 | Memory-stage instruction writes the register file |
| pcWrite | output | 1 | Program counter update enable, 0 while stalled |
| ifIdWrite | output | 1 | Fetch/decode register load enable, 0 while stalled |
| bubbleSel | output | 1 | 1 selects an all-zero control bundle into the decode/execute register |

## Verification
A missing or wrong comparison shows at the ports in the same cycle the decode stage holds the consumer: the outputs simply fail to drop, or drop when no real producer exists. Inside a running pipeline the same fault surfaces as a consumer held one or two cycles too few or too many, which shows up as a wrong hold count for that instruction as soon as it leaves decode. Incoherent strobes (fetch held while decode advances, or a bubble with no hold) appear on the very cycle they occur.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  // Strobes passed from the interlock control to the top-level outputs.
  typedef struct packed {
    logic holdFetch;
    logic holdDecode;
    logic insertBubble;
  } stallStrobes_t;

  // Indices of producer stages in the comparison matrix.
  localparam int unsigned PROD_EX  = 0;
  localparam int unsigned PROD_MEM = 1;

  // Indices of decode sources in the comparison matrix.
  localparam int unsigned SRC_A = 0;
  localparam int unsigned SRC_B = 1;

endpackage

// File: rtl/hazard_match.sv
// Comparison datapath: one comparator per (producer stage, decode source) pair.
module hazard_match #(
  parameter int unsigned REG_W         = 5,
  parameter int unsigned NUM_PROD      = 2,
  parameter int unsigned NUM_SRC       = 2,
  parameter bit          ZERO_REG_HARD = 1'b1
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0]  srcReg,
  input  logic [NUM_SRC-1:0]             srcUsed,
  input  logic [NUM_PROD-1:0][REG_W-1:0] prodRd,
  input  logic [NUM_PROD-1:0]            prodWe,
  output logic [NUM_PROD-1:0][NUM_SRC-1:0] hitMatrix
);

  logic [NUM_PROD-1:0] prodLive;

  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    if (ZERO_REG_HARD) begin : g_zeroHard
      // Writes to register 0 are discarded, so such a producer is harmless.
      assign prodLive[p] = prodWe[p] && (prodRd[p] != '0);
    end else begin : g_zeroSoft
      assign prodLive[p] = prodWe[p];
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign hitMatrix[p][s] = prodLive[p] && srcUsed[s] &&
                               (srcReg[s] == prodRd[p]);
    end
  end

endmodule

// File: rtl/hazard_ctl.sv
// Control: folds the comparison matrix into the stall strobes.
module hazard_ctl
  import hazard_pkg::*;
#(
  parameter int unsigned NUM_PROD = 2,
  parameter int unsigned NUM_SRC  = 2
) (
  input  logic [NUM_PROD-1:0][NUM_SRC-1:0] hitMatrix,
  output stallStrobes_t                    strobes
);

  logic [NUM_PROD-1:0] stageHit;
  logic                anyHit;

  for (genvar p = 0; p < NUM_PROD; p++) begin : g_stage
    assign stageHit[p] = |hitMatrix[p];
  end

  assign anyHit = |stageHit;

  always_comb begin
    strobes              = '0;
    strobes.holdFetch    = anyHit;
    strobes.holdDecode   = anyHit;
    strobes.insertBubble = anyHit;
  end

endmodule

// File: rtl/hazard_interlock.sv
// Top: packs the pipeline fields for the matcher and drives the stall enables.
module hazard_interlock
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] idRs1,
  input  logic             idRs1Used,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idRs2Used,
  input  logic [REG_W-1:0] exRd,
  input  logic             exRegWrite,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  output logic             pcWrite,
  output logic             ifIdWrite,
  output logic             bubbleSel
);

  localparam int unsigned NUM_PROD = 2;
  localparam int unsigned NUM_SRC  = 2;

  logic [NUM_SRC-1:0][REG_W-1:0]    srcReg;
  logic [NUM_SRC-1:0]               srcUsed;
  logic [NUM_PROD-1:0][REG_W-1:0]   prodRd;
  logic [NUM_PROD-1:0]              prodWe;
  logic [NUM_PROD-1:0][NUM_SRC-1:0] hitMatrix;
  stallStrobes_t                    strobes;

  always_comb begin
    srcReg[SRC_A]   = idRs1;
    srcReg[SRC_B]   = idRs2;
    srcUsed[SRC_A]  = idRs1Used;
    srcUsed[SRC_B]  = idRs2Used;
    prodRd[PROD_EX]  = exRd;
    prodRd[PROD_MEM] = memRd;
    prodWe[PROD_EX]  = exRegWrite;
    prodWe[PROD_MEM] = memRegWrite;
  end

  hazard_match #(
    .REG_W        (REG_W),
    .NUM_PROD     (NUM_PROD),
    .NUM_SRC      (NUM_SRC),
    .ZERO_REG_HARD(1'b1)
  ) u_match (
    .srcReg   (srcReg),
    .srcUsed  (srcUsed),
    .prodRd   (prodRd),
    .prodWe   (prodWe),
    .hitMatrix(hitMatrix)
  );

  hazard_ctl #(
    .NUM_PROD(NUM_PROD),
    .NUM_SRC (NUM_SRC)
  ) u_ctl (
    .hitMatrix(hitMatrix),
    .strobes  (strobes)
  );

  assign pcWrite   = !strobes.holdFetch;
  assign ifIdWrite = !strobes.holdDecode;
  assign bubbleSel = strobes.insertBubble;

endmodule

// File: rtl/hazard_interlock_chk.sv
// Port-level checks for hazard_interlock, attached with bind below.
module hazard_interlock_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] idRs1,
  input logic             idRs1Used,
  input logic [REG_W-1:0] idRs2,
  input logic             idRs2Used,
  input logic [REG_W-1:0] exRd,
  input logic             exRegWrite,
  input logic [REG_W-1:0] memRd,
  input logic             memRegWrite,
  input logic             pcWrite,
  input logic             ifIdWrite,
  input logic             bubbleSel
);

  logic exLive, memLive, exA, exB, memA, memB, known;

  always_comb begin
    known   = !$isunknown({idRs1, idRs1Used, idRs2, idRs2Used, exRd, exRegWrite,
                           memRd, memRegWrite, pcWrite, ifIdWrite, bubbleSel});
    exLive  = exRegWrite && (exRd != '0);
    memLive = memRegWrite && (memRd != '0);
    exA     = exLive && idRs1Used && (idRs1 == exRd);
    exB     = exLive && idRs2Used && (idRs2 == exRd);
    memA    = memLive && idRs1Used && (idRs1 == memRd);
    memB    = memLive && idRs2Used && (idRs2 == memRd);
    if (known) begin
      // R1
      a_r1_ex_first_src: assert (!exA || (!pcWrite && bubbleSel))
        else $error("R1 execute-stage first-source match did not stall");
      // R2
      a_r2_mem_producer: assert (!(memA || memB) || (!pcWrite && bubbleSel))
        else $error("R2 memory-stage match did not stall");
      // R3
      a_r3_second_src: assert (!(exB || memB) || !ifIdWrite)
        else $error("R3 second-source match did not hold decode");
      // R4 R5 R6 R7
      a_r7_no_match_flows: assert ((exA || exB || memA || memB) ||
                                   (pcWrite && ifIdWrite && !bubbleSel))
        else $error("R7 stall without a qualifying match");
      // R8
      a_r8_coherent: assert ((pcWrite == ifIdWrite) && (bubbleSel == !pcWrite))
        else $error("R8 stall strobes disagree");
    end
  end

endmodule

bind hazard_interlock hazard_interlock_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_hazard_interlock.sv
module tb_hazard_interlock;

  localparam int unsigned REG_W  = 5;
  localparam time         PERIOD = 10ns;
  localparam int          MAXI   = 16;

  logic clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  logic [REG_W-1:0] idRs1 = '0, idRs2 = '0, exRd = '0, memRd = '0;
  logic idRs1Used = 1'b0, idRs2Used = 1'b0, exRegWrite = 1'b0, memRegWrite = 1'b0;
  logic pcWrite, ifIdWrite, bubbleSel;

  hazard_interlock #(.REG_W(REG_W)) dut (
    .idRs1(idRs1), .idRs1Used(idRs1Used), .idRs2(idRs2), .idRs2Used(idRs2Used),
    .exRd(exRd), .exRegWrite(exRegWrite), .memRd(memRd), .memRegWrite(memRegWrite),
    .pcWrite(pcWrite), .ifIdWrite(ifIdWrite), .bubbleSel(bubbleSel)
  );

  int checks = 0;
  int errors = 0;

  // Program storage for the pipeline model.
  logic [REG_W-1:0] pRd [MAXI], pRa [MAXI], pRb [MAXI];
  logic             pWe [MAXI], pUa [MAXI], pUb [MAXI];
  int               holdCnt [MAXI];
  int               expHold [MAXI];

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic bit hitOf(input logic [REG_W-1:0] rd, input logic we,
                               input logic [REG_W-1:0] src, input logic used);
    return we && (rd != 0) && used && (src == rd);
  endfunction

  function automatic bit expStall();
    return hitOf(exRd, exRegWrite, idRs1, idRs1Used) || hitOf(exRd, exRegWrite, idRs2, idRs2Used) ||
           hitOf(memRd, memRegWrite, idRs1, idRs1Used) || hitOf(memRd, memRegWrite, idRs2, idRs2Used);
  endfunction

  // Drive one set of stage fields, then check all three outputs mid-cycle.
  task automatic applyCheck(input string req,
                            input logic [REG_W-1:0] a, input logic ua,
                            input logic [REG_W-1:0] b, input logic ub,
                            input logic [REG_W-1:0] xr, input logic xw,
                            input logic [REG_W-1:0] mr, input logic mw);
    @(posedge clk);
    idRs1 = a; idRs1Used = ua; idRs2 = b; idRs2Used = ub;
    exRd = xr; exRegWrite = xw; memRd = mr; memRegWrite = mw;
    @(negedge clk);
    begin
      bit s = expStall();
      check(req, {pcWrite, ifIdWrite, bubbleSel}, {!s, !s, s});
    end
  endtask

  // Schedule model: decode cycle of each instruction from the no-bypass rule.
  task automatic computeExpected(input int n);
    int idCyc [MAXI];
    for (int i = 0; i < n; i++) begin
      int c = (i == 0) ? 0 : idCyc[i-1] + 1;
      for (int j = 0; j < i; j++) begin
        if (hitOf(pRd[j], pWe[j], pRa[i], pUa[i]) || hitOf(pRd[j], pWe[j], pRb[i], pUb[i]))
          if (idCyc[j] + 3 > c) c = idCyc[j] + 3;
      end
      idCyc[i]   = c;
      expHold[i] = (i == 0) ? 0 : c - idCyc[i-1] - 1;
    end
  endtask

  // Pipeline model that obeys the DUT's enables; counts decode holds per instruction.
  task automatic runProgram(input int n);
    int pc = 0, idI = -1, exI = -1, memI = -1, guard = 0;
    for (int i = 0; i < n; i++) holdCnt[i] = 0;
    while ((pc < n || idI >= 0 || exI >= 0 || memI >= 0) && guard < 200) begin
      @(posedge clk);
      idRs1 = (idI >= 0) ? pRa[idI] : '0;  idRs1Used = (idI >= 0) ? pUa[idI] : 1'b0;
      idRs2 = (idI >= 0) ? pRb[idI] : '0;  idRs2Used = (idI >= 0) ? pUb[idI] : 1'b0;
      exRd  = (exI >= 0) ? pRd[exI] : '0;  exRegWrite  = (exI >= 0) ? pWe[exI] : 1'b0;
      memRd = (memI >= 0) ? pRd[memI] : '0; memRegWrite = (memI >= 0) ? pWe[memI] : 1'b0;
      @(negedge clk);
      memI = exI;
      if (bubbleSel) begin
        if (idI >= 0) holdCnt[idI]++;
        exI = -1;
      end else begin
        exI = idI;
      end
      if (pcWrite) begin
        idI = (pc < n) ? pc : -1;
        pc++;
      end
      guard++;
    end
  endtask

  task automatic setIns(input int i, input logic [REG_W-1:0] rd, input logic we,
                        input logic [REG_W-1:0] ra, input logic ua,
                        input logic [REG_W-1:0] rb, input logic ub);
    pRd[i] = rd; pWe[i] = we; pRa[i] = ra; pUa[i] = ua; pRb[i] = rb; pUb[i] = ub;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));

    // Idle state: nothing in any stage.
    @(negedge clk);
    check("R7 idle", {pcWrite, ifIdWrite, bubbleSel}, 3'b110);

    // Directed corner cases.
    applyCheck("R1 ex first source",  5'd5, 1, 5'd0, 0, 5'd5, 1, 5'd0, 0);
    applyCheck("R2 mem first source", 5'd7, 1, 5'd1, 0, 5'd0, 0, 5'd7, 1);
    applyCheck("R2 mem second source", 5'd1, 1, 5'd9, 1, 5'd4, 1, 5'd9, 1);
    applyCheck("R3 store data ex",    5'd5, 1, 5'd3, 1, 5'd3, 1, 5'd0, 0);
    applyCheck("R4 unused sources",   5'd6, 0, 5'd6, 0, 5'd6, 1, 5'd6, 1);
    applyCheck("R5 no write",         5'd8, 1, 5'd8, 1, 5'd8, 0, 5'd8, 0);
    applyCheck("R6 dest zero",        5'd0, 1, 5'd0, 1, 5'd0, 1, 5'd0, 1);
    applyCheck("R7 no match",         5'd2, 1, 5'd3, 1, 5'd4, 1, 5'd5, 1);
    @(negedge clk);
    check("R4 unused source stall", bubbleSel, 0);

    // Random stage contents, small register range to force matches.
    for (int k = 0; k < 400; k++) begin
      applyCheck("R8 random",
                 REG_W'($urandom % 4), 1'($urandom), REG_W'($urandom % 4), 1'($urandom),
                 REG_W'($urandom % 4), 1'($urandom), REG_W'($urandom % 4), 1'($urandom));
    end

    // Directed program: add / load / load / or / store.
    setIns(0, 5'd5, 1, 5'd2, 1, 5'd1, 1);
    setIns(1, 5'd3, 1, 5'd5, 1, 5'd0, 0);
    setIns(2, 5'd2, 1, 5'd2, 1, 5'd0, 0);
    setIns(3, 5'd3, 1, 5'd5, 1, 5'd3, 1);
    setIns(4, 5'd0, 0, 5'd5, 1, 5'd3, 1);
    runProgram(5);
    check("R9 add holds",   holdCnt[0], 0);
    check("R9 load1 holds", holdCnt[1], 2);
    check("R9 load2 holds", holdCnt[2], 0);
    check("R9 or holds",    holdCnt[3], 1);
    check("R9 store holds", holdCnt[4], 2);

    // Random programs against the schedule model.
    for (int t = 0; t < 40; t++) begin
      int n = 4 + int'($urandom % 9);
      for (int i = 0; i < n; i++)
        setIns(i, REG_W'($urandom % 5), 1'($urandom), REG_W'($urandom % 5), 1'($urandom),
               REG_W'($urandom % 5), 1'($urandom));
      computeExpected(n);
      runProgram(n);
      for (int i = 0; i < n; i++) check("R9 random program", holdCnt[i], expHold[i]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule